// File: doc/BRIEF.md
# Soft-Ramped Two-Channel Volume Attenuator

This block applies a digital volume to a stereo stream of 24-bit two's-complement samples. Each channel has its own 8-bit level code. The code maps linearly onto a gain of code/255, so code 0 silences the channel and code 255 passes the sample at unity. The block never applies a new level at once. The working gain of each channel moves toward its target one code at a time. A step is allowed only after a fixed number of frame strobes, and that number depends on the sampling speed mode.

A shared soft-mute input sets the target of both channels to zero. Releasing it sets the target back to each channel's level code. A ramp that is still running turns around at once from the gain it has reached. A level change during a ramp works the same way.

The scaled sample of each channel is registered. It comes out one clock after the sample and gain that produce it.

Top module: `soft_ramp_atten`

## Requirements
- R1: The output of each channel equals sample × gain / 255, rounded to the nearest integer with the sign applied to the magnitude. It appears one clock after the sample is presented. Gain 255 returns the sample unchanged and gain 0 returns exactly zero.
- R2: The two channels keep separate gains and separate step pacing. Activity on one channel never changes the gain of the other.
- R3: While a channel's gain differs from its target, the gain moves one code toward the target on every Nth frame strobe. N is 4 for speed code 0 (normal), 8 for code 1 (double) and 16 for code 2 (quad). The first step falls on the Nth strobe after the gain departs from its target.
- R4: In normal speed, a sweep from code 255 down to code 0 ends exactly on the 1020th frame strobe. After the 1019th strobe the gain is 1.
- R5: While soft mute is high, the target of both channels is 0, so a gain of g reaches zero after g × N strobes. When mute goes low, the gain climbs back to the level code at the same pace.
- R6: Releasing mute before the gain reaches zero reverses the ramp from the present gain. The next step goes upward.
- R7: A level code that changes mid-ramp redirects the gain toward the new code, starting from the present gain.
- R8: The gain changes only on a clock that carries a frame strobe, and by at most one code per step. Clocks without a strobe leave it unchanged.
- R9: On the first clock after reset is released, each gain loads its target directly: 0 when mute is high, otherwise the level code. No ramp takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-clock strobe per sample frame |
| speed_i | input | 2 | Speed mode: 0 normal, 1 double, 2 quad |
| mute_i | input | 1 | Soft mute request for both channels |
| level_l_i | input | 8 | Left level code (gain = code/255) |
| level_r_i | input | 8 | Right level code |
| smp_l_i | input | 24 | Left input sample, two's complement |
| smp_r_i | input | 24 | Right input sample, two's complement |
| smp_l_o | output | 24 | Left scaled sample, registered |
| smp_r_o | output | 24 | Right scaled sample, registered |

## Verification
A gain step takes effect on the clock edge that carries the Nth strobe, and the scaled sample follows one edge later. The bench therefore waits one strobe-free clock after a burst of strobes and compares on the falling edge that comes after. The bench feeds the constant sample 255 × 32768 during the ramp tests. This makes every output an exact multiple of the gain, so the gain can be read directly off the output port. In the multiply sweep, each gain is loaded through the reset path. Each sample is then checked one clock after it is driven.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int BASE_FRAMES = 4;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;
endpackage

// File: rtl/atten_ramp.sv
module atten_ramp
  import atten_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          frame_i,
  input  speed_e        speed_i,
  input  logic          mute_i,
  input  logic [GW-1:0] level_i,
  output logic [GW-1:0] gain_o
);
  localparam int CNT_W = $clog2(4 * BASE_FRAMES);

  logic [GW-1:0]    tgt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic [GW-1:0]    gain_q;

  assign tgt = mute_i ? '0 : level_i;

  always_comb begin
    unique case (speed_i)
      SPD_NORMAL: lim = CNT_W'(BASE_FRAMES - 1);
      SPD_DOUBLE: lim = CNT_W'(2 * BASE_FRAMES - 1);
      default:    lim = CNT_W'(4 * BASE_FRAMES - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '1;
      cnt_q  <= '0;
    end else if (load_i) begin
      gain_q <= tgt;
      cnt_q  <= '0;
    end else if (gain_q == tgt) begin
      cnt_q  <= '0;
    end else if (frame_i) begin
      if (cnt_q >= lim) begin
        cnt_q  <= '0;
        gain_q <= (gain_q < tgt) ? gain_q + GW'(1) : gain_q - GW'(1);
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int DW = 24,
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] smp_i,
  input  logic [GW-1:0] gain_i,
  output logic [DW-1:0] smp_o
);
  localparam int GMAX = (1 << GW) - 1;
  // shift is a multiple of GW so that (2^SH - 1) / GMAX is exact
  localparam int SH   = ((DW + 2 * GW) / GW) * GW;
  localparam int PW   = DW + GW;
  localparam int WW   = PW + SH;
  localparam logic [SH-1:0] RECIP = {SH{1'b1}} / SH'(GMAX);
  localparam logic [WW-1:0] HALF  = WW'(1) << (SH - 1);

  logic          neg;
  logic [DW-1:0] mag;
  logic [PW-1:0] prod;
  logic [WW-1:0] wide;
  logic [DW-1:0] q;
  logic          unused_bits;

  assign neg  = smp_i[DW-1];
  assign mag  = neg ? (~smp_i + DW'(1)) : smp_i;
  assign prod = PW'(mag) * PW'(gain_i);
  assign wide = WW'(prod) * WW'(RECIP) + HALF;
  assign q    = wide[SH +: DW];
  assign unused_bits = ^{wide[SH-1:0], wide[WW-1:SH+DW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_o <= '0;
    else         smp_o <= neg ? (~q + DW'(1)) : q;
  end
endmodule

// File: rtl/soft_ramp_atten.sv
module soft_ramp_atten
  import atten_pkg::*;
#(
  parameter int DW = 24,
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic [1:0]    speed_i,
  input  logic          mute_i,
  input  logic [GW-1:0] level_l_i,
  input  logic [GW-1:0] level_r_i,
  input  logic [DW-1:0] smp_l_i,
  input  logic [DW-1:0] smp_r_i,
  output logic [DW-1:0] smp_l_o,
  output logic [DW-1:0] smp_r_o
);
  localparam int NUM_CH = 2;

  logic          load_q;
  speed_e        speed;
  logic [GW-1:0] level  [NUM_CH];
  logic [DW-1:0] smp_in [NUM_CH];
  logic [DW-1:0] smp_out[NUM_CH];
  logic [GW-1:0] gain_q [NUM_CH];

  assign speed     = speed_e'(speed_i);
  assign level[0]  = level_l_i;
  assign level[1]  = level_r_i;
  assign smp_in[0] = smp_l_i;
  assign smp_in[1] = smp_r_i;
  assign smp_l_o   = smp_out[0];
  assign smp_r_o   = smp_out[1];

  // one-shot direct load of the gains after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= 1'b0;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    atten_ramp #(.GW(GW)) i_ramp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_q),
      .frame_i (frame_i),
      .speed_i (speed),
      .mute_i  (mute_i),
      .level_i (level[ch]),
      .gain_o  (gain_q[ch])
    );

    atten_scale #(.DW(DW), .GW(GW)) i_scale (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_in[ch]),
      .gain_i (gain_q[ch]),
      .smp_o  (smp_out[ch])
    );
  end
endmodule

// File: rtl/soft_ramp_atten_chk.sv
module soft_ramp_atten_chk #(
  parameter int DW = 24,
  parameter int GW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_i,
  input logic          mute_i,
  input logic          load_i,
  input logic [GW-1:0] level_l_i,
  input logic [GW-1:0] level_r_i,
  input logic [GW-1:0] gain_l_i,
  input logic [GW-1:0] gain_r_i,
  input logic [DW-1:0] smp_l_i,
  input logic [DW-1:0] smp_r_i,
  input logic [DW-1:0] smp_l_o,
  input logic [DW-1:0] smp_r_o
);
  logic [GW-1:0] gain [2];
  logic [GW-1:0] eff  [2];
  logic [DW-1:0] si   [2];
  logic [DW-1:0] so   [2];

  assign gain[0] = gain_l_i;
  assign gain[1] = gain_r_i;
  assign eff[0]  = mute_i ? '0 : level_l_i;
  assign eff[1]  = mute_i ? '0 : level_r_i;
  assign si[0]   = smp_l_i;
  assign si[1]   = smp_r_i;
  assign so[0]   = smp_l_o;
  assign so[1]   = smp_r_o;

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_gain_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !frame_i) |=> $stable(gain[c]));

    assert_unit_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> (gain[c] == $past(gain[c])) || (gain[c] == $past(gain[c]) + GW'(1))
                  || (gain[c] + GW'(1) == $past(gain[c])));

    assert_rise_toward_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && gain[c] < eff[c]) |=> gain[c] >= $past(gain[c]));

    assert_fall_toward_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && gain[c] > eff[c]) |=> gain[c] <= $past(gain[c]));

    assert_direct_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> gain[c] == $past(eff[c]));

    assert_zero_gain_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gain[c] == '0 |=> so[c] == '0);

    assert_unity_gain_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gain[c] == '1 |=> so[c] == $past(si[c]));
  end
endmodule

bind soft_ramp_atten soft_ramp_atten_chk #(.DW(DW), .GW(GW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_i   (frame_i),
  .mute_i    (mute_i),
  .load_i    (load_q),
  .level_l_i (level_l_i),
  .level_r_i (level_r_i),
  .gain_l_i  (gain_q[0]),
  .gain_r_i  (gain_q[1]),
  .smp_l_i   (smp_l_i),
  .smp_r_i   (smp_r_i),
  .smp_l_o   (smp_l_o),
  .smp_r_o   (smp_r_o)
);

// File: tb/test_soft_ramp_atten.sv
`timescale 1ns/1ps
module test_soft_ramp_atten;
  localparam int UNIT = 32768;
  localparam int PROBE = 255 * UNIT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic [1:0]  speed = 2'd0;
  logic        mute = 1'b0;
  logic [7:0]  lvl_l = 8'd255;
  logic [7:0]  lvl_r = 8'd255;
  logic [23:0] s_l = 24'(PROBE);
  logic [23:0] s_r = 24'(PROBE);
  logic [23:0] o_l, o_r;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  soft_ramp_atten i_soft_ramp_atten (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .speed_i(speed), .mute_i(mute),
    .level_l_i(lvl_l), .level_r_i(lvl_r), .smp_l_i(s_l), .smp_r_i(s_r),
    .smp_l_o(o_l), .smp_r_o(o_r));

  function automatic int exp_scale(int s, int g);
    longint m = (s < 0) ? -longint'(s) : longint'(s);
    longint q = (m * g + 127) / 255;
    return (s < 0) ? -int'(q) : int'(q);
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // gain readout: probe sample gives output = gain * UNIT
  task automatic check_gains(string tag, int gl, int gr);
    @(negedge clk);
    cmp({tag, " left"},  $signed(o_l), gl * UNIT);
    cmp({tag, " right"}, $signed(o_r), gr * UNIT);
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame = 1'b1;
      @(negedge clk) frame = 1'b0;
    end
  endtask

  task automatic do_reset(int l, int r);
    @(negedge clk);
    rst_n = 1'b0; lvl_l = 8'(l); lvl_r = 8'(r);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int smp_list[8];
    smp_list = '{0, 1, -1, 8388607, -8388608, 1234567, -765432, 127};

    // R9 reset loads the level directly
    do_reset(255, 100);
    check_gains("R9 reset load", 255, 100);

    // R3 normal pacing, R2 right side untouched
    lvl_l = 8'd250;
    frames(3);  check_gains("R3 normal before step", 255, 100);
    frames(1);  check_gains("R3 normal first step", 254, 100);
    frames(16); check_gains("R3 normal reach", 250, 100);
    frames(8);  check_gains("R2 settled hold", 250, 100);

    // R3 double speed
    speed = 2'd1; lvl_l = 8'd252;
    frames(7);  check_gains("R3 double before step", 250, 100);
    frames(1);  check_gains("R3 double step", 251, 100);
    frames(8);  check_gains("R3 double reach", 252, 100);

    // R3 quad speed
    speed = 2'd2; lvl_l = 8'd250;
    frames(15); check_gains("R3 quad before step", 252, 100);
    frames(1);  check_gains("R3 quad step", 251, 100);
    frames(16); check_gains("R3 quad reach", 250, 100);

    // R4 full sweep in normal speed
    speed = 2'd0;
    do_reset(255, 100);
    lvl_l = 8'd0;
    frames(1019); check_gains("R4 sweep minus one", 1, 100);
    frames(1);    check_gains("R4 sweep end", 0, 100);

    // R5 / R6 soft mute and reversal
    do_reset(200, 80);
    mute = 1'b1;
    frames(40); check_gains("R5 mute ramp down", 190, 70);
    mute = 1'b0;
    frames(4);  check_gains("R6 reversal step", 191, 71);
    frames(36); check_gains("R6 back at level", 200, 80);
    mute = 1'b1;
    frames(800); check_gains("R5 full mute", 0, 0);
    mute = 1'b0;
    frames(320); check_gains("R5 release partial", 80, 80);
    frames(480); check_gains("R5 release full", 200, 80);

    // R7 target change mid-ramp
    lvl_l = 8'd100;
    frames(40); check_gains("R7 heading down", 190, 80);
    lvl_l = 8'd195;
    frames(4);  check_gains("R7 redirected", 191, 80);
    frames(16); check_gains("R7 new target", 195, 80);

    // R8 clocks without strobes do nothing
    lvl_l = 8'd150; lvl_r = 8'd10;
    repeat (100) @(negedge clk);
    check_gains("R8 no strobe", 195, 80);

    // R9 reset under mute loads zero
    mute = 1'b1;
    do_reset(200, 200);
    check_gains("R9 reset under mute", 0, 0);
    mute = 1'b0;

    // R1 multiply sweep over every gain
    for (int g = 0; g < 256; g++) begin
      do_reset(g, 255 - g);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        s_l = 24'(smp_list[k]);
        s_r = 24'(-smp_list[k] + 3 * k);
        @(negedge clk);
        cmp("R1 scale left",  int'($signed(o_l)), exp_scale(smp_list[k], g));
        cmp("R1 scale right", int'($signed(o_r)),
            exp_scale(int'($signed(24'(-smp_list[k] + 3 * k))), 255 - g));
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule